// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a small bank of byte-wide configuration registers that a host reaches through only two I/O addresses. The host first writes a register number to the index port, then reads or writes the data port; that one data-port access goes to the register that was just named, and the index is used up by it. A register number that falls outside the bank, or a data access that was not set up by a fresh index write, hits nothing: reads give all ones and writes are dropped.

One register of the bank, the control register, can always be reached. One of its bits acts as a map-enable that opens the rest of the bank. With that bit clear, every other register reads as all ones and ignores writes. Host software therefore reads the control register, writes it back with map-enable set, touches its target register, and writes the saved value back again. The two low bits of the general configuration register leave the block as the top two bits of a system base address.

Top module: `cfg_index_port`

## Requirements
- R1: A write to the index port (I/O address INDEX_PORT, default 0x22) stores the written byte as the current index and marks it valid from the next cycle on.
- R2: A read of the data port (DATA_PORT, default 0x23) with a valid, reachable index returns that register's contents on io_rdata from the cycle after the read strobe, and io_rdata holds that value until the next read.
- R3: A write to the data port with a valid, reachable index stores io_wdata in that register, and a later indexed read returns it.
- R4: A data-port access made while the index is not valid has no effect on any register, and a read in that case returns 0xFF.
- R5: Every data-port access, read or write, invalidates the index, so a second data access with no index write in between behaves as in R4.
- R6: The control register (index CTRL_IDX, default 0xC3) can always be reached. Every other register in the bank can be reached only while bit MAPEN_BIT (default 4) of the control register is 1; otherwise reads return 0xFF and writes are ignored.
- R7: Indices outside REG_BASE to REG_BASE+NUM_REGS-1 (default 0xB8 to 0xC7) name no register: reads return 0xFF and writes are ignored.
- R8: base_hi always equals bits 1:0 of the general configuration register (index GCFG_IDX, default 0xB8) and changes only in the cycle after a data-port write to that register.
- R9: Reset loads register k (index REG_BASE+k) from byte k of REG_DEFAULTS (bits 8k+7:8k), except that the map-enable bit of the control register is cleared. Reset also invalidates the index and sets io_rdata to 0xFF.
- R10: A read of the index port returns 0xFF. Accesses to any address other than the two ports change nothing, and io_rdata keeps its value.
- R11: When io_wr and io_rd are both high, the cycle is a write only. io_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | AW (16) | I/O address of the current strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered, valid from the cycle after io_rd |
| base_hi | output | 2 | Bits 31:30 of the controller base address |

## Verification
The bench keeps the default bank geometry: sixteen registers from 0xB8 to 0xC7, the control register at 0xC3, map-enable in bit 4 and the general configuration register at 0xB8. It overrides REG_DEFAULTS with a pattern that sets map-enable in the control register's default byte and puts a non-zero value in the base bits. This shows that reset masks map-enable, and that base_hi leaves its reset value once the register is written. Random traffic is drawn over an index window wider than the bank, 0xA8 to 0xD7, so the bench reaches both sides of the bank edge as well as gated and ungated states.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] NO_HIT = 8'hFF;

   typedef struct packed {
      logic idx_wr;
      logic idx_rd;
      logic dat_wr;
      logic dat_rd;
   } io_stb_t;
endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
   import cfg_port_pkg::*;
#(
   parameter int AW = 16,
   parameter logic [AW-1:0] INDEX_PORT = 'h22,
   parameter logic [AW-1:0] DATA_PORT  = 'h23
) (
   input  logic [AW-1:0] io_addr,
   input  logic          io_wr,
   input  logic          io_rd,
   output io_stb_t       stb
);
   logic rd_only;
   logic hit_idx;
   logic hit_dat;

   // a cycle with both strobes is treated as a write
   assign rd_only = io_rd & ~io_wr;
   assign hit_idx = (io_addr == INDEX_PORT);
   assign hit_dat = (io_addr == DATA_PORT);

   always_comb begin
      stb.idx_wr = io_wr   & hit_idx;
      stb.idx_rd = rd_only & hit_idx;
      stb.dat_wr = io_wr   & hit_dat;
      stb.dat_rd = rd_only & hit_dat;
   end
endmodule

// File: rtl/cfg_index_latch.sv
module cfg_index_latch
   import cfg_port_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  io_stb_t           stb,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] idx_q,
   output logic              idx_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q     <= '0;
         idx_valid <= 1'b0;
      end else if (stb.idx_wr) begin
         idx_q     <= wdata;
         idx_valid <= 1'b1;
      end else if (stb.dat_wr | stb.dat_rd) begin
         idx_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_port_pkg::*;
#(
   parameter int NUM_REGS  = 16,
   parameter int CTRL_OFF  = 11,
   parameter int GCFG_OFF  = 0,
   parameter int MAPEN_BIT = 4,
   parameter int BASE_W    = 2,
   parameter logic [NUM_REGS*BYTE_W-1:0] REG_DEFAULTS = '0,
   localparam int OFF_W = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rd_val,
   output logic              map_en,
   output logic [BASE_W-1:0] base_bits
);
   logic [BYTE_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [BYTE_W-1:0] DEF_RAW = REG_DEFAULTS[i*BYTE_W +: BYTE_W];
      localparam logic [BYTE_W-1:0] DEF_VAL = (i == CTRL_OFF)
                                            ? (DEF_RAW & ~(BYTE_W'(1) << MAPEN_BIT))
                                            : DEF_RAW;
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= DEF_VAL;
         else if (wr_en && off == OFF_W'(i))
            regs[i] <= wdata;
      end
   end

   assign rd_val    = regs[off];
   assign map_en    = regs[CTRL_OFF][MAPEN_BIT];
   assign base_bits = regs[GCFG_OFF][BASE_W-1:0];
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int AW = 16,
   parameter logic [AW-1:0] INDEX_PORT = 'h22,
   parameter logic [AW-1:0] DATA_PORT  = 'h23,
   parameter logic [7:0] REG_BASE  = 8'hB8,
   parameter int         NUM_REGS  = 16,
   parameter logic [7:0] CTRL_IDX  = 8'hC3,
   parameter logic [7:0] GCFG_IDX  = 8'hB8,
   parameter int         MAPEN_BIT = 4,
   parameter int         BASE_W    = 2,
   parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] io_addr,
   input  logic          io_wr,
   input  logic          io_rd,
   input  logic [7:0]    io_wdata,
   output logic [7:0]    io_rdata,
   output logic [BASE_W-1:0] base_hi
);
   localparam int OFF_W    = $clog2(NUM_REGS);
   localparam int CTRL_OFF = int'(CTRL_IDX) - int'(REG_BASE);
   localparam int GCFG_OFF = int'(GCFG_IDX) - int'(REG_BASE);

   // elaboration-time parameter checks
   if (NUM_REGS < 2 || (1 << OFF_W) != NUM_REGS)
      begin : g_bad_depth $error("NUM_REGS must be a power of two, at least 2"); end
   if (int'(REG_BASE) + NUM_REGS > 256)
      begin : g_bad_span $error("register bank runs past index 0xFF"); end
   if (CTRL_OFF < 0 || CTRL_OFF >= NUM_REGS || GCFG_OFF < 0 || GCFG_OFF >= NUM_REGS)
      begin : g_bad_idx $error("control or config index outside the bank"); end
   if (CTRL_OFF == GCFG_OFF)
      begin : g_bad_same $error("control and config registers must differ"); end
   if (MAPEN_BIT < 0 || MAPEN_BIT > 7 || BASE_W < 1 || BASE_W > 8)
      begin : g_bad_bits $error("bit position or base width out of range"); end
   if (INDEX_PORT == DATA_PORT)
      begin : g_bad_port $error("index and data ports must differ"); end

   io_stb_t     stb;
   logic [7:0]  idx_q;
   logic        idx_valid;
   logic [8:0]  idx_rel;
   logic        in_bank;
   logic        reach;
   logic [7:0]  rd_val;
   logic        map_en;

   cfg_io_decode #(.AW(AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)) u_dec (
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .stb     (stb)
   );

   cfg_index_latch u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (stb),
      .wdata     (io_wdata),
      .idx_q     (idx_q),
      .idx_valid (idx_valid)
   );

   // below-base indices wrap to >= 256, so one compare covers both edges
   assign idx_rel = {1'b0, idx_q} - {1'b0, REG_BASE};
   assign in_bank = (idx_rel < 9'(NUM_REGS));
   assign reach   = idx_valid & in_bank & ((idx_q == CTRL_IDX) | map_en);

   cfg_reg_bank #(
      .NUM_REGS     (NUM_REGS),
      .CTRL_OFF     (CTRL_OFF),
      .GCFG_OFF     (GCFG_OFF),
      .MAPEN_BIT    (MAPEN_BIT),
      .BASE_W       (BASE_W),
      .REG_DEFAULTS (REG_DEFAULTS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (stb.dat_wr & reach),
      .off       (idx_rel[OFF_W-1:0]),
      .wdata     (io_wdata),
      .rd_val    (rd_val),
      .map_en    (map_en),
      .base_bits (base_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         io_rdata <= NO_HIT;
      else if (stb.idx_rd)
         io_rdata <= NO_HIT;
      else if (stb.dat_rd)
         io_rdata <= reach ? rd_val : NO_HIT;
   end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
   parameter int AW = 16,
   parameter logic [AW-1:0] INDEX_PORT = 'h22,
   parameter logic [AW-1:0] DATA_PORT  = 'h23,
   parameter logic [7:0] REG_BASE = 8'hB8,
   parameter int         NUM_REGS = 16,
   parameter logic [7:0] CTRL_IDX = 8'hC3,
   parameter int         BASE_W   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] io_addr,
   input logic          io_wr,
   input logic          io_rd,
   input logic [7:0]    io_wdata,
   input logic [7:0]    io_rdata,
   input logic [BASE_W-1:0] base_hi,
   input logic [7:0]    idx_q,
   input logic          idx_valid,
   input logic          map_en
);
   logic dat_rd, dat_any, idx_wr, idx_rd, bank_hit;

   assign dat_rd   = io_rd & ~io_wr & (io_addr == DATA_PORT);
   assign dat_any  = (io_rd | io_wr) & (io_addr == DATA_PORT);
   assign idx_wr   = io_wr & (io_addr == INDEX_PORT);
   assign idx_rd   = io_rd & ~io_wr & (io_addr == INDEX_PORT);
   assign bank_hit = (int'(idx_q) >= int'(REG_BASE)) &&
                     (int'(idx_q) <  int'(REG_BASE) + NUM_REGS);

   a_r1_index_capture: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (idx_valid && idx_q == $past(io_wdata)));

   a_r4_stale_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !idx_valid) |=> io_rdata == 8'hFF);

   a_r5_index_spent: assert property (@(posedge clk) disable iff (!rst_n)
      dat_any |=> !idx_valid);

   a_r6_gated_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && idx_valid && bank_hit && idx_q != CTRL_IDX && !map_en) |=> io_rdata == 8'hFF);

   a_r7_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && idx_valid && !bank_hit) |=> io_rdata == 8'hFF);

   a_r8_base_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == DATA_PORT) |=> $stable(base_hi));

   a_r10_index_read: assert property (@(posedge clk) disable iff (!rst_n)
      idx_rd |=> io_rdata == 8'hFF);

   a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_rd && (io_addr == DATA_PORT || io_addr == INDEX_PORT)) |=> $stable(io_rdata));
endmodule

bind cfg_index_port cfg_port_chk #(
   .AW(AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
   .REG_BASE(REG_BASE), .NUM_REGS(NUM_REGS), .CTRL_IDX(CTRL_IDX), .BASE_W(BASE_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .base_hi(base_hi),
   .idx_q(idx_q), .idx_valid(idx_valid), .map_en(map_en)
);

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/1ps
module cfg_index_port_tb_top;
   localparam int         NREG  = 16;
   localparam logic [7:0] RBASE = 8'hB8;
   localparam logic [7:0] CIDX  = 8'hC3;
   localparam logic [7:0] GIDX  = 8'hB8;
   localparam int         MBIT  = 4;
   localparam int         COFF  = int'(CIDX) - int'(RBASE);
   localparam int         GOFF  = int'(GIDX) - int'(RBASE);
   localparam logic [15:0] IPORT = 16'h22;
   localparam logic [15:0] DPORT = 16'h23;

   function automatic logic [NREG*8-1:0] mk_defs();
      logic [NREG*8-1:0] v;
      for (int i = 0; i < NREG; i++) begin
         logic [7:0] b;
         b = 8'(i * 37 + 29);
         if (i == COFF) b = b | 8'h10;
         v[i*8 +: 8] = b;
      end
      return v;
   endfunction
   localparam logic [NREG*8-1:0] DEFS = mk_defs();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [1:0]  base_hi;

   always #2.5 clk = ~clk;

   cfg_index_port #(.REG_DEFAULTS(DEFS)) dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .base_hi(base_hi)
   );

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [7:0] m_regs [NREG];
   logic       m_valid;
   logic [7:0] m_idx;
   logic [7:0] m_rdata;

   function automatic bit m_reach();
      bit inb;
      inb = (int'(m_idx) >= int'(RBASE)) && (int'(m_idx) < int'(RBASE) + NREG);
      return m_valid && inb && (m_idx == CIDX || m_regs[COFF][MBIT]);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic m_reset();
      for (int i = 0; i < NREG; i++) m_regs[i] = DEFS[i*8 +: 8];
      m_regs[COFF][MBIT] = 1'b0;
      m_valid = 1'b0;
      m_idx = '0;
      m_rdata = 8'hFF;
   endtask

   // one bus cycle; model updated, outputs checked one edge later
   task automatic bus(input logic [15:0] a, input bit w, input bit r,
                      input logic [7:0] d, input string tag);
      if (w) begin
         if (a == IPORT) begin m_valid = 1'b1; m_idx = d; end
         else if (a == DPORT) begin
            if (m_reach()) m_regs[int'(m_idx) - int'(RBASE)] = d;
            m_valid = 1'b0;
         end
      end else if (r) begin
         if (a == IPORT) m_rdata = 8'hFF;
         else if (a == DPORT) begin
            m_rdata = m_reach() ? m_regs[int'(m_idx) - int'(RBASE)] : 8'hFF;
            m_valid = 1'b0;
         end
      end
      @(negedge clk);
      io_addr = a; io_wr = w; io_rd = r; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0;
      check(io_rdata == m_rdata, {tag, " rdata"}, io_rdata, m_rdata);
      check(base_hi == m_regs[GOFF][1:0], "R8 base_hi", base_hi, m_regs[GOFF][1:0]);
   endtask

   task automatic rd_reg(input logic [7:0] idx, input string tag);
      bus(IPORT, 1, 0, idx, "R1 index");
      bus(DPORT, 0, 1, 8'h00, tag);
   endtask

   task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d, input string tag);
      bus(IPORT, 1, 0, idx, "R1 index");
      bus(DPORT, 1, 0, d, tag);
   endtask

   task automatic dump_all(input string tag);
      logic [7:0] saved;
      rd_reg(CIDX, tag);
      saved = m_rdata;
      wr_reg(CIDX, saved | 8'h10, tag);
      for (int i = 0; i < NREG; i++) rd_reg(8'(int'(RBASE) + i), tag);
      wr_reg(CIDX, saved, tag);
   endtask

   initial begin
      logic [7:0] sv;
      m_reset();
      repeat (3) @(negedge clk);
      check(io_rdata == 8'hFF, "R9 reset rdata", io_rdata, 8'hFF);
      check(base_hi == DEFS[GOFF*8 +: 2], "R9 reset base_hi", base_hi, DEFS[GOFF*8 +: 2]);
      rst_n = 1'b1;
      // R9 control reset value has map-enable masked
      rd_reg(CIDX, "R9 ctrl reset");
      check(m_rdata[MBIT] == 1'b0, "R9 mapen cleared", m_rdata, 0);
      // R6 gated read and write while map-enable is clear
      rd_reg(GIDX, "R6 gated read");
      wr_reg(GIDX, 8'h02, "R6 gated write");
      // R4 data access with no index
      bus(DPORT, 0, 1, 8'h00, "R4 stale read");
      bus(DPORT, 1, 0, 8'h5A, "R4 stale write");
      // R3 open the map via read-modify-write, R2 read back
      rd_reg(CIDX, "R2 ctrl read");
      sv = m_rdata;
      wr_reg(CIDX, sv | 8'h10, "R3 ctrl write");
      rd_reg(GIDX, "R2 gcfg read");
      wr_reg(GIDX, 8'h02, "R3 gcfg write");
      rd_reg(GIDX, "R3 gcfg readback");
      // R5 second read without a fresh index
      bus(DPORT, 0, 1, 8'h00, "R5 spent index");
      // R7 outside the bank
      wr_reg(8'h20, 8'h77, "R7 outside write");
      rd_reg(8'h20, "R7 outside read");
      rd_reg(8'hB7, "R7 below edge");
      rd_reg(8'hC8, "R7 above edge");
      // R10 index port read and foreign address
      bus(IPORT, 0, 1, 8'h00, "R10 index read");
      rd_reg(8'hC7, "R2 top reg");
      bus(16'h0080, 1, 0, 8'h33, "R10 foreign write");
      bus(16'h0080, 0, 1, 8'h00, "R10 foreign read");
      // R11 both strobes on data port: write only
      bus(IPORT, 1, 0, 8'hC5, "R1 index");
      bus(DPORT, 1, 1, 8'hA6, "R11 both strobes");
      rd_reg(8'hC5, "R11 readback");
      // R6 restore control, map closes again
      wr_reg(CIDX, sv, "R6 restore");
      rd_reg(GIDX, "R6 closed again");
      dump_all("R4 R7 R10 nothing else changed");
      // random traffic
      void'($urandom(32'h1234_5EED));
      for (int n = 0; n < 1500; n++) begin
         int unsigned k;
         logic [7:0] ri;
         k = $urandom % 10;
         ri = 8'(8'hA8 + ($urandom % 48));
         if ($urandom % 4 == 0) ri = CIDX;
         case (k)
            0, 1, 2: bus(IPORT, 1, 0, ri, "R1 rand index");
            3, 4:    bus(DPORT, 0, 1, 8'h00, "R2 rand read");
            5, 6:    bus(DPORT, 1, 0, 8'($urandom), "R3 rand write");
            7:       bus(IPORT, 0, 1, 8'h00, "R10 rand index read");
            8:       bus(16'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R10 rand addr");
            default: bus(DPORT, 1, 1, 8'($urandom), "R11 rand both");
         endcase
      end
      dump_all("R3 final contents");
      // R9 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_reset();
      check(io_rdata == 8'hFF, "R9 rerun rdata", io_rdata, 8'hFF);
      bus(DPORT, 0, 1, 8'h00, "R9 index invalid after reset");
      dump_all("R9 defaults after reset");
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule